// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Trap and Interrupt Entry

This block is the central sequencer of a small multicycle processor that runs a subset of a 32-bit load/store instruction set: word load, word store, register-register ALU operations, branch-if-equal and jump. Each instruction takes three to five clock cycles. In every cycle the sequencer drives the select and write-enable lines of an external datapath: the memory port, the instruction register, the register file, the two ALU operand multiplexers, the ALU function class and the program-counter source. It decides the next step from the opcode held in the instruction register, the ALU overflow flag and the ALU zero flag.

Two extra states redirect execution to a fixed handler address. One is a trap state, entered from decode when the opcode is not supported or from the execute step when the ALU overflows. It subtracts four from the already-incremented program counter so that the exception PC holds the address of the faulting instruction. The other is an interrupt state, entered only when an instruction finishes while an interrupt request is pending. It saves the incremented PC, so the interrupted program resumes at the next instruction. Both states also write the cause and status registers and report a cause code for the cause register.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: After reset the block is in the fetch step: mem_rd=1, ir_wr=1, addr_sel=0, alu_a_sel=0, alu_b_sel=01, alu_op=00, pc_src=00, pc_wr=1. In every step, any control output that is not listed for that step is 0, and exc_code is 0 outside the two exception steps.
- R2: Fetch is always followed by decode: alu_a_sel=0, alu_b_sel=11, alu_op=00, with no write enable active.
- R3: Opcode 6'h23 (load) runs address (alu_a_sel=1, alu_b_sel=10, alu_op=00), then memory read (mem_rd=1, addr_sel=1), then write-back (dst_sel=0, rf_wr=1, wb_sel=1), then returns to fetch.
- R4: Opcode 6'h2B (store) runs address, then memory write (mem_wr=1, addr_sel=1), then returns to fetch.
- R5: Opcode 6'h00 (register ALU operation) runs execute (alu_a_sel=1, alu_b_sel=00, alu_op=10), then completion (dst_sel=1, rf_wr=1, wb_sel=0), then returns to fetch.
- R6: Opcode 6'h04 (branch) runs one step with alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_src=01, pc_wr_cond=1. In every step, pc_load equals pc_wr OR (pc_wr_cond AND alu_zero).
- R7: Opcode 6'h02 (jump) runs one step with pc_src=10 and pc_wr=1.
- R8: Any other opcode at decode leads to the trap step: alu_a_sel=0, alu_b_sel=01, alu_op=01, cause_wr=1, epc_wr=1, pc_wr=1, epc_trap_sel=1, pc_src=11, exc_code=10. The trap step is followed by fetch.
- R9: If alu_ovf is 1 in the execute step, the next step is the trap step with exc_code=12, and no register-file write is issued for that instruction.
- R10: If irq_pending is 1 in the last step of an instruction, the next step is the interrupt step instead of fetch: cause_wr=1, epc_wr=1, pc_wr=1, epc_trap_sel=0, pc_src=11, exc_code=0. It is followed by fetch. irq_pending has no effect in any other step.
- R11: mem_rd and mem_wr are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the held instruction |
| alu_zero | input | 1 | ALU result-is-zero flag |
| alu_ovf | input | 1 | ALU signed-overflow flag |
| irq_pending | input | 1 | An enabled interrupt is waiting |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address: 0 = PC, 1 = ALU result register |
| ir_wr | output | 1 | Instruction register load |
| dst_sel | output | 1 | Destination register: 0 = rt field, 1 = rd field |
| rf_wr | output | 1 | Register file write |
| wb_sel | output | 1 | Write-back data: 0 = ALU result, 1 = memory data |
| alu_a_sel | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU operand B: 00 reg B, 01 four, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target, 11 handler address |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if the ALU zero flag is set |
| pc_load | output | 1 | Resulting PC write enable |
| epc_wr | output | 1 | Exception PC register write |
| cause_wr | output | 1 | Cause and status register write |
| epc_trap_sel | output | 1 | Exception PC source: 0 = PC, 1 = ALU result (PC - 4) |
| exc_code | output | 5 | Cause code for the cause register |

## Verification
The checker covers the relations that hold on every cycle: the memory strobes never overlap, the handler source always comes with both exception writes, a fetch is always followed by decode, an exception step is always followed by fetch, an instruction that writes the register file ends in fetch or the interrupt step, and an overflow in execute always leads to a trap with code 12 and no register write. The directed scenarios check the complete step sequences for each opcode class and the branch enable for both values of the zero flag. They also check that an interrupt raised early in an instruction is ignored, that an unsupported opcode after an overflow trap reports code 10 and not 12, and that a request held through a trap step does not produce an interrupt step.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int EXC_W = 5;

    typedef enum logic [3:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_MADDR  = 4'd2,
        ST_MREAD  = 4'd3,
        ST_LDWB   = 4'd4,
        ST_MWRITE = 4'd5,
        ST_EXEC   = 4'd6,
        ST_RDONE  = 4'd7,
        ST_BRANCH = 4'd8,
        ST_JUMP   = 4'd9,
        ST_TRAP   = 4'd10,
        ST_INTR   = 4'd11
    } state_e;

    typedef enum logic [2:0] {
        OC_LOAD,
        OC_STORE,
        OC_ALU,
        OC_BRANCH,
        OC_JUMP,
        OC_BAD
    } opclass_e;

    typedef struct packed {
        logic             mem_rd;
        logic             mem_wr;
        logic             addr_sel;
        logic             ir_wr;
        logic             dst_sel;
        logic             rf_wr;
        logic             wb_sel;
        logic             alu_a_sel;
        logic [1:0]       alu_b_sel;
        logic [1:0]       alu_op;
        logic [1:0]       pc_src;
        logic             pc_wr;
        logic             pc_wr_cond;
        logic             epc_wr;
        logic             cause_wr;
        logic             epc_trap_sel;
        logic [EXC_W-1:0] exc_code;
    } ctl_t;

    typedef struct packed {
        state_e st;
        logic   ovf_cause;
    } seq_t;

endpackage

// File: rtl/mcc_opclass.sv
module mcc_opclass
    import mcc_pkg::*;
#(
    parameter int              OP_W      = 6,
    parameter logic [OP_W-1:0] OP_LOAD   = 6'h23,
    parameter logic [OP_W-1:0] OP_STORE  = 6'h2B,
    parameter logic [OP_W-1:0] OP_ALU    = 6'h00,
    parameter logic [OP_W-1:0] OP_BRANCH = 6'h04,
    parameter logic [OP_W-1:0] OP_JUMP   = 6'h02
) (
    input  logic [OP_W-1:0] opcode,
    output opclass_e        opclass
);

    always_comb begin
        if (opcode == OP_LOAD)        opclass = OC_LOAD;
        else if (opcode == OP_STORE)  opclass = OC_STORE;
        else if (opcode == OP_ALU)    opclass = OC_ALU;
        else if (opcode == OP_BRANCH) opclass = OC_BRANCH;
        else if (opcode == OP_JUMP)   opclass = OC_JUMP;
        else                          opclass = OC_BAD;
    end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  state_e   cur,
    input  opclass_e opclass,
    input  logic     alu_ovf,
    input  logic     irq_pending,
    output state_e   nxt
);

    state_e end_of_instr;

    // An instruction boundary: fetch next, unless an interrupt waits.
    assign end_of_instr = irq_pending ? ST_INTR : ST_FETCH;

    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (opclass)
                    OC_LOAD, OC_STORE: nxt = ST_MADDR;
                    OC_ALU:            nxt = ST_EXEC;
                    OC_BRANCH:         nxt = ST_BRANCH;
                    OC_JUMP:           nxt = ST_JUMP;
                    default:           nxt = ST_TRAP;
                endcase
            end
            ST_MADDR:  nxt = (opclass == OC_STORE) ? ST_MWRITE : ST_MREAD;
            ST_MREAD:  nxt = ST_LDWB;
            ST_EXEC:   nxt = alu_ovf ? ST_TRAP : ST_RDONE;
            ST_LDWB, ST_MWRITE, ST_RDONE, ST_BRANCH, ST_JUMP:
                       nxt = end_of_instr;
            ST_TRAP, ST_INTR:
                       nxt = ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
    import mcc_pkg::*;
#(
    parameter logic [EXC_W-1:0] CODE_INT = 5'd0,
    parameter logic [EXC_W-1:0] CODE_RI  = 5'd10,
    parameter logic [EXC_W-1:0] CODE_OV  = 5'd12
) (
    input  state_e cur,
    input  logic   ovf_cause,
    output ctl_t   ctl
);

    always_comb begin
        ctl = '0;
        unique case (cur)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_wr     = 1'b1;
                ctl.alu_b_sel = 2'b01;
                ctl.pc_wr     = 1'b1;
            end
            ST_DECODE: begin
                ctl.alu_b_sel = 2'b11;
            end
            ST_MADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = 2'b10;
            end
            ST_MREAD: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctl.rf_wr  = 1'b1;
                ctl.wb_sel = 1'b1;
            end
            ST_MWRITE: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_EXEC: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_op    = 2'b10;
            end
            ST_RDONE: begin
                ctl.dst_sel = 1'b1;
                ctl.rf_wr   = 1'b1;
            end
            ST_BRANCH: begin
                ctl.alu_a_sel  = 1'b1;
                ctl.alu_op     = 2'b01;
                ctl.pc_src     = 2'b01;
                ctl.pc_wr_cond = 1'b1;
            end
            ST_JUMP: begin
                ctl.pc_src = 2'b10;
                ctl.pc_wr  = 1'b1;
            end
            ST_TRAP: begin
                // ALU computes PC - 4 so the faulting address is saved.
                ctl.alu_b_sel    = 2'b01;
                ctl.alu_op       = 2'b01;
                ctl.pc_src       = 2'b11;
                ctl.pc_wr        = 1'b1;
                ctl.epc_wr       = 1'b1;
                ctl.cause_wr     = 1'b1;
                ctl.epc_trap_sel = 1'b1;
                ctl.exc_code     = ovf_cause ? CODE_OV : CODE_RI;
            end
            ST_INTR: begin
                ctl.pc_src   = 2'b11;
                ctl.pc_wr    = 1'b1;
                ctl.epc_wr   = 1'b1;
                ctl.cause_wr = 1'b1;
                ctl.exc_code = CODE_INT;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mcc_pkg::*;
#(
    parameter int              OP_W      = 6,
    parameter logic [OP_W-1:0] OP_LOAD   = 6'h23,
    parameter logic [OP_W-1:0] OP_STORE  = 6'h2B,
    parameter logic [OP_W-1:0] OP_ALU    = 6'h00,
    parameter logic [OP_W-1:0] OP_BRANCH = 6'h04,
    parameter logic [OP_W-1:0] OP_JUMP   = 6'h02,
    parameter logic [EXC_W-1:0] CODE_INT = 5'd0,
    parameter logic [EXC_W-1:0] CODE_RI  = 5'd10,
    parameter logic [EXC_W-1:0] CODE_OV  = 5'd12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  opcode,
    input  logic             alu_zero,
    input  logic             alu_ovf,
    input  logic             irq_pending,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             addr_sel,
    output logic             ir_wr,
    output logic             dst_sel,
    output logic             rf_wr,
    output logic             wb_sel,
    output logic             alu_a_sel,
    output logic [1:0]       alu_b_sel,
    output logic [1:0]       alu_op,
    output logic [1:0]       pc_src,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic             pc_load,
    output logic             epc_wr,
    output logic             cause_wr,
    output logic             epc_trap_sel,
    output logic [EXC_W-1:0] exc_code
);

    seq_t     seq_d, seq_q;
    opclass_e opclass;
    state_e   st_nxt;
    ctl_t     ctl;

    mcc_opclass #(
        .OP_W      (OP_W),
        .OP_LOAD   (OP_LOAD),
        .OP_STORE  (OP_STORE),
        .OP_ALU    (OP_ALU),
        .OP_BRANCH (OP_BRANCH),
        .OP_JUMP   (OP_JUMP)
    ) opclass_i (
        .opcode  (opcode),
        .opclass (opclass)
    );

    mcc_next_state next_i (
        .cur         (seq_q.st),
        .opclass     (opclass),
        .alu_ovf     (alu_ovf),
        .irq_pending (irq_pending),
        .nxt         (st_nxt)
    );

    mcc_out_decode #(
        .CODE_INT (CODE_INT),
        .CODE_RI  (CODE_RI),
        .CODE_OV  (CODE_OV)
    ) out_i (
        .cur       (seq_q.st),
        .ovf_cause (seq_q.ovf_cause),
        .ctl       (ctl)
    );

    always_comb begin
        seq_d    = seq_q;
        seq_d.st = st_nxt;
        // Remember which trap source is taken; cleared at each decode.
        if (seq_q.st == ST_DECODE)    seq_d.ovf_cause = 1'b0;
        else if (seq_q.st == ST_EXEC) seq_d.ovf_cause = alu_ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st        <= ST_FETCH;
            seq_q.ovf_cause <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_rd       = ctl.mem_rd;
    assign mem_wr       = ctl.mem_wr;
    assign addr_sel     = ctl.addr_sel;
    assign ir_wr        = ctl.ir_wr;
    assign dst_sel      = ctl.dst_sel;
    assign rf_wr        = ctl.rf_wr;
    assign wb_sel       = ctl.wb_sel;
    assign alu_a_sel    = ctl.alu_a_sel;
    assign alu_b_sel    = ctl.alu_b_sel;
    assign alu_op       = ctl.alu_op;
    assign pc_src       = ctl.pc_src;
    assign pc_wr        = ctl.pc_wr;
    assign pc_wr_cond   = ctl.pc_wr_cond;
    assign pc_load      = ctl.pc_wr | (ctl.pc_wr_cond & alu_zero);
    assign epc_wr       = ctl.epc_wr;
    assign cause_wr     = ctl.cause_wr;
    assign epc_trap_sel = ctl.epc_trap_sel;
    assign exc_code     = ctl.exc_code;

endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       alu_ovf,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       ir_wr,
    input logic       rf_wr,
    input logic [1:0] alu_b_sel,
    input logic [1:0] alu_op,
    input logic [1:0] pc_src,
    input logic       pc_wr,
    input logic       epc_wr,
    input logic       cause_wr,
    input logic       epc_trap_sel,
    input logic [4:0] exc_code
);

    assert_mem_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> (alu_b_sel == 2'b11 && !pc_wr && !rf_wr && !mem_rd));

    assert_handler_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_src == 2'b11) |-> (epc_wr && cause_wr && pc_wr));

    assert_exc_then_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        epc_wr |=> (ir_wr && pc_src == 2'b00));

    assert_wb_ends_instr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr |=> (ir_wr || epc_wr));

    assert_ovf_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 2'b10 && alu_ovf) |=>
            (epc_wr && epc_trap_sel && exc_code == 5'd12 && !rf_wr));

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk chk_i (.*);

// File: tb/mc_ctrl_fsm_tb_top.sv
module mc_ctrl_fsm_tb_top;

    localparam int K_FETCH = 0, K_DECODE = 1, K_MADDR = 2, K_MREAD = 3,
                   K_LDWB = 4, K_MWRITE = 5, K_EXEC = 6, K_RDONE = 7,
                   K_BRANCH = 8, K_JUMP = 9, K_TRAP = 10, K_INTR = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic       alu_zero = 1'b0;
    logic       alu_ovf = 1'b0;
    logic       irq_pending = 1'b0;
    logic       mem_rd, mem_wr, addr_sel, ir_wr, dst_sel, rf_wr, wb_sel, alu_a_sel;
    logic [1:0] alu_b_sel, alu_op, pc_src;
    logic       pc_wr, pc_wr_cond, pc_load, epc_wr, cause_wr, epc_trap_sel;
    logic [4:0] exc_code;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    mc_ctrl_fsm dut_i (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
        .alu_ovf(alu_ovf), .irq_pending(irq_pending),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_wr(ir_wr),
        .dst_sel(dst_sel), .rf_wr(rf_wr), .wb_sel(wb_sel), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src), .pc_wr(pc_wr),
        .pc_wr_cond(pc_wr_cond), .pc_load(pc_load), .epc_wr(epc_wr),
        .cause_wr(cause_wr), .epc_trap_sel(epc_trap_sel), .exc_code(exc_code)
    );

    // Order: mem_rd mem_wr addr_sel ir_wr dst_sel rf_wr wb_sel alu_a
    //        alu_b[2] alu_op[2] pc_src[2] pc_wr pc_cond epc_wr cause_wr trap_sel code[5]
    function automatic logic [23:0] exp_vec(input int k, input logic [4:0] code);
        logic rd = 0, wr = 0, ad = 0, ir = 0, ds = 0, rf = 0, wb = 0, aa = 0;
        logic [1:0] ab = 0, op = 0, ps = 0;
        logic pw = 0, pc = 0, ew = 0, cw = 0, ts = 0;
        logic [4:0] cd = 0;
        case (k)
            K_FETCH:  begin rd = 1; ir = 1; ab = 2'b01; pw = 1; end
            K_DECODE: begin ab = 2'b11; end
            K_MADDR:  begin aa = 1; ab = 2'b10; end
            K_MREAD:  begin rd = 1; ad = 1; end
            K_LDWB:   begin rf = 1; wb = 1; end
            K_MWRITE: begin wr = 1; ad = 1; end
            K_EXEC:   begin aa = 1; op = 2'b10; end
            K_RDONE:  begin ds = 1; rf = 1; end
            K_BRANCH: begin aa = 1; op = 2'b01; ps = 2'b01; pc = 1; end
            K_JUMP:   begin ps = 2'b10; pw = 1; end
            K_TRAP:   begin ab = 2'b01; op = 2'b01; ps = 2'b11; pw = 1; ew = 1;
                            cw = 1; ts = 1; cd = code; end
            K_INTR:   begin ps = 2'b11; pw = 1; ew = 1; cw = 1; cd = code; end
            default:  ;
        endcase
        return {rd, wr, ad, ir, ds, rf, wb, aa, ab, op, ps, pw, pc, ew, cw, ts, cd};
    endfunction

    task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_step(input string req, input int k, input logic [4:0] code);
        logic [23:0] act;
        act = {mem_rd, mem_wr, addr_sel, ir_wr, dst_sel, rf_wr, wb_sel, alu_a_sel,
               alu_b_sel, alu_op, pc_src, pc_wr, pc_wr_cond, epc_wr, cause_wr,
               epc_trap_sel, exc_code};
        check_val(req, {8'h0, act}, {8'h0, exp_vec(k, code)});
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    // Load with an early interrupt request that must be ignored (R3, R10).
    task automatic t_load();
        check_step("R1 fetch", K_FETCH, 0);
        opcode = 6'h23; irq_pending = 1'b1;
        nxt(); check_step("R2 decode", K_DECODE, 0);
        nxt(); check_step("R3 load address", K_MADDR, 0);
        nxt(); check_step("R10 early irq ignored, R3 load read", K_MREAD, 0);
        irq_pending = 1'b0;
        nxt(); check_step("R3 load write-back", K_LDWB, 0);
        nxt(); check_step("R3 back to fetch", K_FETCH, 0);
    endtask

    task automatic t_store();
        check_step("R1 fetch", K_FETCH, 0);
        opcode = 6'h2B;
        nxt(); check_step("R2 decode", K_DECODE, 0);
        nxt(); check_step("R4 store address", K_MADDR, 0);
        nxt(); check_step("R4 store write", K_MWRITE, 0);
        check_val("R11 strobes exclusive", {31'h0, mem_rd & mem_wr}, 32'h0);
        nxt(); check_step("R4 back to fetch", K_FETCH, 0);
    endtask

    task automatic t_alu(input logic ovf, input logic irq_end);
        check_step("R1 fetch", K_FETCH, 0);
        opcode = 6'h00;
        nxt(); check_step("R2 decode", K_DECODE, 0);
        nxt(); check_step("R5 execute", K_EXEC, 0);
        alu_ovf = ovf;
        nxt();
        alu_ovf = 1'b0;
        if (ovf) begin
            check_step("R9 overflow trap code 12", K_TRAP, 5'd12);
            check_val("R9 no register write", {31'h0, rf_wr}, 32'h0);
        end else begin
            check_step("R5 completion", K_RDONE, 0);
            irq_pending = irq_end;
            nxt();
            irq_pending = 1'b0;
            if (irq_end) begin
                check_step("R10 interrupt step", K_INTR, 5'd0);
                nxt();
            end
        end
        if (ovf) nxt();
        check_step("R5 R9 R10 back to fetch", K_FETCH, 0);
    endtask

    task automatic t_branch(input logic z);
        check_step("R1 fetch", K_FETCH, 0);
        check_val("R6 pc_load in fetch", {31'h0, pc_load}, 32'h1);
        opcode = 6'h04;
        nxt(); check_step("R2 decode", K_DECODE, 0);
        nxt(); check_step("R6 branch", K_BRANCH, 0);
        alu_zero = z; #1;
        check_val("R6 pc_load follows zero", {31'h0, pc_load}, {31'h0, z});
        alu_zero = 1'b0; #1;
        check_val("R6 pc_load low when zero clear", {31'h0, pc_load}, 32'h0);
        nxt(); check_step("R6 back to fetch", K_FETCH, 0);
    endtask

    task automatic t_jump();
        check_step("R1 fetch", K_FETCH, 0);
        opcode = 6'h02;
        nxt(); check_step("R2 decode", K_DECODE, 0);
        nxt(); check_step("R7 jump", K_JUMP, 0);
        irq_pending = 1'b1;
        nxt(); check_step("R10 interrupt after jump", K_INTR, 5'd0);
        irq_pending = 1'b0;
        nxt(); check_step("R7 back to fetch", K_FETCH, 0);
    endtask

    // Unsupported opcode; irq held through the trap step must be ignored.
    task automatic t_illegal(input logic [5:0] op);
        check_step("R1 fetch", K_FETCH, 0);
        opcode = op;
        nxt(); check_step("R2 decode", K_DECODE, 0);
        nxt(); check_step("R8 reserved-opcode trap code 10", K_TRAP, 5'd10);
        irq_pending = 1'b1;
        nxt(); check_step("R8 R10 fetch after trap despite irq", K_FETCH, 0);
        irq_pending = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        check_step("R1 reset state", K_FETCH, 0);
        rst_n = 1'b1;
        nxt();
        check_step("R2 decode after reset", K_DECODE, 0);
        opcode = 6'h2B;
        nxt(); nxt(); nxt();
        check_step("R4 store sequence after reset", K_FETCH, 0);
        t_load();
        t_store();
        t_alu(1'b0, 1'b0);
        t_alu(1'b0, 1'b1);
        t_alu(1'b1, 1'b0);
        t_illegal(6'h3F);
        t_alu(1'b1, 1'b0);
        t_illegal(6'h05);
        t_branch(1'b1);
        t_branch(1'b0);
        t_jump();
        t_load();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule